// File: doc/BRIEF.md
# Dual-Channel PCM Serial Port

This block carries 8-bit companded voice samples for two channels between parallel sample registers and external PCM serial lines. A bit clock sets the pace. Transmit and receive each have their own frame sync, which recurs at a nominal 8 kHz. The block runs on a fast system clock. It finds the rising and falling edges of the bit clock by oversampling it, so the bit clock must be synchronous to the system clock and much slower than it. Any common bit clock rate from 64 kHz to 2048 kHz fits, including 96, 192, 384, 768, 1536 and 1544 kHz.

A layout input sets how the channels map onto the pins. In split layout each channel has its own transmit lane and its own receive lane, and both lanes use the same timing. In shared layout a single lane carries 16 bits per frame: channel 1 followed at once by channel 2. Transmit uses lane 1 and receive uses lane 2. Every sample is sent most significant bit first. The transmit pins behave as open-drain style outputs: a driver enable is high only during a data bit, and the pin floats otherwise. A disable input keeps both enables low.

Transmit and receive each use the same three-state machine:
- `LINK_IDLE` goes to `LINK_ARMED` when a frame sync is seen on a falling bit clock edge.
- `LINK_ARMED` goes to `LINK_SHIFT` on the next rising edge. A fresh sync while in `LINK_ARMED` re-arms it.
- `LINK_SHIFT` goes back to `LINK_IDLE` after the last bit. A sync seen during `LINK_SHIFT` goes to `LINK_ARMED`, which either restarts the frame early or chains the next frame.

Top module: `pcm_dual_port`

## Requirements
- R1: After reset both transmit enables (`tx_oe1`, `tx_oe2`) are 0, `rx_valid` is 0, and both received words are 0.
- R2: With `split_mode`=1, a transmit sync seen on a falling bit clock edge causes the following effects. From the next rising edge, `tx_line1` carries sample 1 and `tx_line2` carries sample 2. Each is sent MSB first, one bit per bit clock period, for 8 periods, with both enables high.
- R3: With `split_mode`=0, `tx_line1` carries 16 bits per frame: sample 1 MSB first, then sample 2 MSB first. `tx_oe2` stays 0. The layout is taken from `split_mode` at the sync.
- R4: Outside the bit periods of a transmit frame, both enables are 0. This covers the sync period and every period after the last bit until the next frame.
- R5: While `tx_dis`=1, both enables are 0. Frame timing keeps running, so the next frame after `tx_dis` returns to 0 is sent normally.
- R6: The transmit samples are captured at the sync. Changing `tx_samp1` or `tx_samp2` later in the frame does not alter the bits sent.
- R7: With `split_mode`=1, a receive sync starts a frame. `rx_line1` and `rx_line2` are then sampled on the 8 falling edges that follow. The MSB-first bytes appear on `rx_samp1` and `rx_samp2`.
- R8: With `split_mode`=0, 16 bits are taken from `rx_line2`. The first 8 go to `rx_samp1` and the last 8 go to `rx_samp2`. `rx_line1` is ignored.
- R9: The received words change only when a frame is complete. At that point `rx_valid` is high for exactly one system clock. At all other times the words hold their value.
- R10: A sync that arrives before the current frame is complete restarts the bit count. The partial receive byte is discarded with no `rx_valid`, and the partial transmit frame is abandoned.
- R11: A sync seen on the falling edge that samples the last bit of a frame chains the next frame with no idle period. The last bit is still received and sent intact.
- R12: Transmit and receive are framed independently. A receive sync alone does not enable the transmit pins, and receive lanes are not captured without a receive sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | PCM bit clock, synchronous to clk |
| fs_tx | input | 1 | Transmit frame sync |
| fs_rx | input | 1 | Receive frame sync |
| split_mode | input | 1 | 1 = one lane per channel, 0 = one shared 16-bit lane |
| tx_dis | input | 1 | Forces both transmit enables low |
| tx_samp1 | input | 8 | Channel 1 sample to send |
| tx_samp2 | input | 8 | Channel 2 sample to send |
| rx_line1 | input | 1 | Receive lane 1 |
| rx_line2 | input | 1 | Receive lane 2 |
| tx_line1 | output | 1 | Transmit lane 1 data |
| tx_oe1 | output | 1 | Transmit lane 1 driver enable |
| tx_line2 | output | 1 | Transmit lane 2 data |
| tx_oe2 | output | 1 | Transmit lane 2 driver enable |
| rx_samp1 | output | 8 | Last complete channel 1 receive byte |
| rx_samp2 | output | 8 | Last complete channel 2 receive byte |
| rx_valid | output | 1 | One-cycle strobe when new receive bytes land |

## Verification
Errors in the transmit state or bit counter show up on the lane pins within one bit clock period. A state stuck in shift leaves an enable high into the idle gap. A counter that is off by one shifts every bit, or cuts the frame one period early or late. The wrong layout either enables lane 2 in shared layout or scrambles the bit order.

Errors on the receive side show up only at the end of a frame. They appear as wrong bytes, a strobe in the wrong frame, or a strobe that is missing. The bench therefore compares every completed word against a queue of expected words. It also confirms that truncated frames and frames with no receive sync leave the held words untouched.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    // Shared framing states for the transmit and receive engines.
    typedef enum logic [1:0] {
        LINK_IDLE  = 2'd0,
        LINK_ARMED = 2'd1,
        LINK_SHIFT = 2'd2
    } link_state_e;

endpackage

// File: rtl/pcm_bclk_edges.sv
module pcm_bclk_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_clk,
    output logic rise,
    output logic fall
);

    logic bclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
        end else begin
            bclk_q <= bit_clk;
        end
    end

    // One-cycle strobes at each bit clock transition.
    assign rise = bit_clk & ~bclk_q;
    assign fall = ~bit_clk & bclk_q;

endmodule

// File: rtl/pcm_tx_engine.sv
module pcm_tx_engine
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise,
    input  logic                fall,
    input  logic                fs,
    input  logic                split_mode,
    input  logic [SAMPLE_W-1:0] samp1,
    input  logic [SAMPLE_W-1:0] samp2,
    output logic [1:0]          lane_d,
    output logic [1:0]          lane_drv
);

    localparam int FRAME_W = 2 * SAMPLE_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_SPLIT  = CNT_W'(SAMPLE_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHARED = CNT_W'(FRAME_W - 1);

    link_state_e        state, state_nx;
    logic [FRAME_W-1:0] hold_q;
    logic [FRAME_W-1:0] shift_q;
    logic               hold_split_q;
    logic               act_split_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               drv_q;
    logic [CNT_W-1:0]   last;
    logic               sync;

    assign sync = fall & fs;
    assign last = act_split_q ? LAST_SPLIT : LAST_SHARED;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            LINK_IDLE: begin
                if (sync) state_nx = LINK_ARMED;
            end
            LINK_ARMED: begin
                if (sync)      state_nx = LINK_ARMED;
                else if (rise) state_nx = LINK_SHIFT;
            end
            LINK_SHIFT: begin
                if (sync)                      state_nx = LINK_ARMED;
                else if (rise && cnt_q == last) state_nx = LINK_IDLE;
            end
            default: state_nx = LINK_IDLE;
        endcase
    end

    // State register with its datapath: capture at sync, load and shift on rises.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state        <= LINK_IDLE;
            hold_q       <= '0;
            hold_split_q <= 1'b0;
            shift_q      <= '0;
            act_split_q  <= 1'b0;
            cnt_q        <= '0;
        end else begin
            state <= state_nx;
            if (sync) begin
                hold_q       <= {samp1, samp2};
                hold_split_q <= split_mode;
            end
            if (state == LINK_ARMED && rise) begin
                shift_q     <= hold_q;
                act_split_q <= hold_split_q;
                cnt_q       <= '0;
            end else if (state == LINK_SHIFT && rise && cnt_q != last) begin
                shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // Output register: driver enable changes only on rising bit clock edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= 1'b0;
        end else if (rise) begin
            drv_q <= (state_nx == LINK_SHIFT);
        end
    end

    // Lane 1 sees the top of the register; lane 2 the top of the lower half.
    assign lane_d   = {shift_q[SAMPLE_W-1], shift_q[FRAME_W-1]};
    assign lane_drv = {drv_q & act_split_q, drv_q};

    // R4: the lanes are never driven while no frame is in progress.
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LINK_IDLE) |-> !drv_q);

    // R2/R3: the bit count never runs past the last bit of the active layout.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LINK_SHIFT) |-> (cnt_q <= last));

endmodule

// File: rtl/pcm_rx_engine.sv
module pcm_rx_engine
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise,
    input  logic                fall,
    input  logic                fs,
    input  logic                split_mode,
    input  logic                line1,
    input  logic                line2,
    output logic [SAMPLE_W-1:0] word1,
    output logic [SAMPLE_W-1:0] word2,
    output logic                valid
);

    localparam int FRAME_W = 2 * SAMPLE_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_SPLIT  = CNT_W'(SAMPLE_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHARED = CNT_W'(FRAME_W - 1);

    link_state_e        state, state_nx;
    logic [FRAME_W-1:0] shift_q;
    logic [FRAME_W-1:0] shifted;
    logic               split_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   last;
    logic               sync;
    logic               take;

    assign sync = fall & fs;
    assign last = split_q ? LAST_SPLIT : LAST_SHARED;
    assign take = fall && (state == LINK_SHIFT);

    // Split layout fills each half from its own lane; shared fills all from lane 2.
    always_comb begin
        if (split_q) begin
            shifted = {shift_q[FRAME_W-2:SAMPLE_W], line1,
                       shift_q[SAMPLE_W-2:0], line2};
        end else begin
            shifted = {shift_q[FRAME_W-2:0], line2};
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LINK_IDLE: begin
                if (sync) state_nx = LINK_ARMED;
            end
            LINK_ARMED: begin
                if (sync)      state_nx = LINK_ARMED;
                else if (rise) state_nx = LINK_SHIFT;
            end
            LINK_SHIFT: begin
                if (sync)                      state_nx = LINK_ARMED;
                else if (fall && cnt_q == last) state_nx = LINK_IDLE;
            end
            default: state_nx = LINK_IDLE;
        endcase
    end

    // State register and bit assembly.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= LINK_IDLE;
            shift_q <= '0;
            split_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state <= state_nx;
            if (sync) begin
                cnt_q   <= '0;
                split_q <= split_mode;
            end else if (take) begin
                shift_q <= shifted;
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // Output register: words land only when the final bit arrives.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word1 <= '0;
            word2 <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (take && cnt_q == last) begin
                word1 <= shifted[FRAME_W-1:SAMPLE_W];
                word2 <= shifted[SAMPLE_W-1:0];
                valid <= 1'b1;
            end
        end
    end

    // R9: held words change only together with the strobe.
    a_r9_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable({word1, word2}));

    // R9: the strobe lasts a single system clock.
    a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R10: an armed frame always starts counting from zero.
    a_r10_armed_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LINK_ARMED) |-> (cnt_q == '0));

endmodule

// File: rtl/pcm_dual_port.sv
module pcm_dual_port #(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_clk,
    input  logic                fs_tx,
    input  logic                fs_rx,
    input  logic                split_mode,
    input  logic                tx_dis,
    input  logic [SAMPLE_W-1:0] tx_samp1,
    input  logic [SAMPLE_W-1:0] tx_samp2,
    input  logic                rx_line1,
    input  logic                rx_line2,
    output logic                tx_line1,
    output logic                tx_oe1,
    output logic                tx_line2,
    output logic                tx_oe2,
    output logic [SAMPLE_W-1:0] rx_samp1,
    output logic [SAMPLE_W-1:0] rx_samp2,
    output logic                rx_valid
);

    logic       rise, fall;
    logic [1:0] lane_d, lane_drv;

    pcm_bclk_edges u_edges (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_clk (bit_clk),
        .rise    (rise),
        .fall    (fall)
    );

    pcm_tx_engine #(.SAMPLE_W(SAMPLE_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .fall       (fall),
        .fs         (fs_tx),
        .split_mode (split_mode),
        .samp1      (tx_samp1),
        .samp2      (tx_samp2),
        .lane_d     (lane_d),
        .lane_drv   (lane_drv)
    );

    pcm_rx_engine #(.SAMPLE_W(SAMPLE_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .fall       (fall),
        .fs         (fs_rx),
        .split_mode (split_mode),
        .line1      (rx_line1),
        .line2      (rx_line2),
        .word1      (rx_samp1),
        .word2      (rx_samp2),
        .valid      (rx_valid)
    );

    // The disable masks the pad drivers only; framing keeps running.
    assign tx_line1 = lane_d[0];
    assign tx_line2 = lane_d[1];
    assign tx_oe1   = lane_drv[0] & ~tx_dis;
    assign tx_oe2   = lane_drv[1] & ~tx_dis;

endmodule

// File: tb/tb_pcm_dual_port.sv
`timescale 1ns/1ps
module tb_pcm_dual_port;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n, bit_clk, fs_tx, fs_rx, split_mode, tx_dis;
    logic [W-1:0] tx_samp1, tx_samp2, rx_samp1, rx_samp2;
    logic         rx_line1, rx_line2, tx_line1, tx_oe1, tx_line2, tx_oe2, rx_valid;

    int n_checks = 0;
    int n_fail   = 0;
    logic [2*W-1:0] exp_q[$];
    string          tag_q[$];

    always #4 clk = ~clk;

    pcm_dual_port #(.SAMPLE_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .fs_tx(fs_tx), .fs_rx(fs_rx),
        .split_mode(split_mode), .tx_dis(tx_dis), .tx_samp1(tx_samp1), .tx_samp2(tx_samp2),
        .rx_line1(rx_line1), .rx_line2(rx_line2), .tx_line1(tx_line1), .tx_oe1(tx_oe1),
        .tx_line2(tx_line2), .tx_oe2(tx_oe2), .rx_samp1(rx_samp1), .rx_samp2(rx_samp2),
        .rx_valid(rx_valid)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h exp %0h", tag, got, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever the design hands over a word.
    always @(negedge clk) begin : rx_monitor
        logic [2*W-1:0] e;
        string          t;
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                chk("R9/R10/R12 unexpected rx word", {rx_samp1, rx_samp2}, 32'hDEAD);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {rx_samp1, rx_samp2}, e);
            end
        end
    end

    // One bit clock period: 4 clocks high, then 4 low; sample tx in the low half.
    task automatic bit_period(input logic l1, input logic l2, input logic ftx, input logic frx,
                              input logic e_oe1, input logic e_oe2, input logic e_d1,
                              input logic e_d2, input string tag);
        @(negedge clk);
        bit_clk = 1'b1; rx_line1 = l1; rx_line2 = l2; fs_tx = 1'b0; fs_rx = 1'b0;
        repeat (4) @(negedge clk);
        bit_clk = 1'b0; fs_tx = ftx; fs_rx = frx;
        repeat (2) @(negedge clk);
        chk({tag, " oe1"}, tx_oe1, e_oe1);
        chk({tag, " oe2"}, tx_oe2, e_oe2);
        if (e_oe1) chk({tag, " line1"}, tx_line1, e_d1);
        if (e_oe2) chk({tag, " line2"}, tx_line2, e_d2);
        @(negedge clk);
    endtask

    // Driver: one frame; pushes the expected receive word to the scoreboard.
    task automatic frame(input logic [W-1:0] t1, input logic [W-1:0] t2,
                         input logic [W-1:0] r1, input logic [W-1:0] r2,
                         input logic [W-1:0] n1, input logic [W-1:0] n2,
                         input bit skip, input bit chain, input int stop, input int gap,
                         input bit tx_on, input bit rx_on, input string tag);
        int nb;
        int last;
        logic [2*W-1:0] tw;
        logic [2*W-1:0] rw;
        nb   = split_mode ? W : 2 * W;
        last = (stop == 0) ? nb : stop;
        tw   = {t1, t2};
        rw   = {r1, r2};
        if (rx_on && last == nb) begin
            exp_q.push_back(rw);
            tag_q.push_back({tag, " rx word"});
        end
        if (!skip) begin
            tx_samp1 = t1; tx_samp2 = t2;
            bit_period(1'b0, 1'b0, tx_on, rx_on, 1'b0, 1'b0, 1'b0, 1'b0, "R4 float in sync period");
        end
        for (int i = 1; i <= last; i++) begin
            logic l1, l2, d1, d2, o1, o2, ftx, frx;
            if (i == 2) begin
                tx_samp1 = n1; tx_samp2 = n2;   // R6: late change must not matter
            end
            if (split_mode) begin
                l1 = r1[W-i]; l2 = r2[W-i]; d1 = t1[W-i]; d2 = t2[W-i]; o1 = 1'b1; o2 = 1'b1;
            end else begin
                l2 = rw[2*W-i]; l1 = ~l2; d1 = tw[2*W-i]; d2 = 1'b0; o1 = 1'b1; o2 = 1'b0;
            end
            if (!tx_on || tx_dis) begin
                o1 = 1'b0; o2 = 1'b0;
            end
            ftx = chain && (i == last) && tx_on;
            frx = chain && (i == last) && rx_on;
            bit_period(l1, l2, ftx, frx, o1, o2, d1, d2, tag);
        end
        for (int g = 0; g < gap; g++) begin
            bit_period(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 float after frame");
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired got 1 exp 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0; bit_clk = 1'b0; fs_tx = 1'b0; fs_rx = 1'b0; split_mode = 1'b1;
        tx_dis = 1'b0; tx_samp1 = '0; tx_samp2 = '0; rx_line1 = 1'b0; rx_line2 = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 reset oe1", tx_oe1, 0);
        chk("R1 reset oe2", tx_oe2, 0);
        chk("R1 reset valid", rx_valid, 0);
        chk("R1 reset words", {rx_samp1, rx_samp2}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Split layout, two patterns (R2, R6, R7, R4)
        split_mode = 1'b1;
        frame(8'hA5, 8'h3C, 8'h96, 8'h1F, 8'h00, 8'hFF, 0, 0, 0, 2, 1, 1, "R2/R6/R7 split");
        frame(8'h81, 8'h7E, 8'h0F, 8'hF0, 8'h7E, 8'h81, 0, 0, 0, 2, 1, 1, "R2/R7 split");

        // Shared layout (R3, R8)
        split_mode = 1'b0;
        frame(8'hC3, 8'h5A, 8'hE1, 8'h7B, 8'h00, 8'h00, 0, 0, 0, 2, 1, 1, "R3/R8 shared");

        // Disable masks the pins, framing continues (R5)
        split_mode = 1'b1;
        tx_dis = 1'b1;
        frame(8'hFF, 8'h00, 8'h3A, 8'hC5, 8'h00, 8'h00, 0, 0, 0, 1, 1, 1, "R5 disabled");
        tx_dis = 1'b0;
        frame(8'h69, 8'h96, 8'h21, 8'h12, 8'h00, 8'h00, 0, 0, 0, 1, 1, 1, "R5 after enable");

        // Independent framing (R12)
        frame(8'h12, 8'h34, 8'h44, 8'hBB, 8'h12, 8'h34, 0, 0, 0, 1, 0, 1, "R12 rx only");
        frame(8'h56, 8'h78, 8'h11, 8'h22, 8'h56, 8'h78, 0, 0, 0, 1, 1, 0, "R12 tx only");
        chk("R12 rx words untouched without rx sync", {rx_samp1, rx_samp2}, 16'h44BB);

        // Early sync truncates, then a full frame follows (R10)
        frame(8'h6C, 8'h93, 8'h55, 8'hAA, 8'hD2, 8'h2D, 0, 1, 3, 0, 1, 1, "R10 truncated");
        chk("R10/R9 partial byte discarded", {rx_samp1, rx_samp2}, 16'h44BB);
        frame(8'hD2, 8'h2D, 8'hC8, 8'h37, 8'h00, 8'h00, 1, 0, 0, 2, 1, 1, "R10 restarted");

        // Back-to-back shared frames (R11)
        split_mode = 1'b0;
        frame(8'h9C, 8'h63, 8'h1E, 8'hE1, 8'h4B, 8'hB4, 0, 1, 0, 0, 1, 1, "R11 first");
        frame(8'h4B, 8'hB4, 8'h71, 8'h8E, 8'h00, 8'h00, 1, 0, 0, 2, 1, 1, "R11 chained");

        repeat (4) @(negedge clk);
        chk("R9 scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule